// File: doc/BRIEF.md
# Network Interrupt Status Aggregator

This block gathers per-port interrupt requests from up to five network module slots and holds them in two 16-bit status words whose bits are active-low: a bit at 0 marks a pending request for one port. Slot 0 owns the whole first word, one bit per port. The other four slots share the second word, four ports each. A peripheral raises a request with a one-cycle raise strobe carrying a slot and a port number, and withdraws it with a drop strobe of the same form. Both strobes may fire in the same cycle.

The processor sees one combined interrupt line and reads the two status words through a small combinational read port at two word addresses. The line comes from a two-state machine. In state LINE_QUIET the output is low. The transition QUIET_TO_RAISED is taken on the first clock edge at which any status bit is 0. In state LINE_RAISED the output is high. The transition RAISED_TO_QUIET is taken on the first clock edge at which both words are all ones. Because of this register, the line follows the status words one cycle late.

Top module: `nirq_aggregator`

## Requirements
- R1: After reset both status words read 0xFFFF, and the interrupt line is low.
- R2: A raise strobe for slot 0, port p (0..15) clears bit p of the direct word (read address 0x20) on the next clock edge.
- R3: A raise strobe for slot s in 1..4 and port p in 0..3 clears bit 4*(s-1)+p of the shared word (read address 0x22) on the next clock edge.
- R4: A drop strobe for a slot and port sets the same bit back to 1 on the next clock edge.
- R5: The interrupt line goes high one clock after any status bit becomes 0. It goes low one clock after both words return to 0xFFFF.
- R6: Address 0x20 reads the direct word and 0x22 reads the shared word. Any other address reads 0x0000. Reading never changes a status bit.
- R7: A strobe with a slot number above 4, or with a port number above 3 for slots 1..4, changes no bit.
- R8: A raise and a drop on different bits in the same cycle both take effect.
- R9: A raise and a drop on the same bit in the same cycle leave that bit pending (0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_vld | input | 1 | One-cycle strobe that raises a request |
| raise_slot | input | 3 | Slot number for the raise |
| raise_port | input | 4 | Port number for the raise |
| drop_vld | input | 1 | One-cycle strobe that withdraws a request |
| drop_slot | input | 3 | Slot number for the drop |
| drop_port | input | 4 | Port number for the drop |
| rd_addr | input | 8 | Word address for a status read |
| rd_data | output | 16 | Status word at rd_addr (combinational) |
| net_irq | output | 1 | Combined interrupt line, active high |

## Verification
The bench builds the block with its default parameters: 16-bit words, five slots and four ports per shared slot. With these values every bit of both words can be reached, up to bit 15 of the shared word (slot 4, port 3). The 3-bit slot field and the 4-bit port field also let the bench drive slot numbers 5 to 7 and port numbers 4 to 15 on the shared slots. These are the out-of-range requests that must be ignored.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

    // Which status word a request lands in
    typedef enum logic {
        WSEL_DIRECT = 1'b0,
        WSEL_SHARED = 1'b1
    } word_sel_e;

    // Result of routing one slot/port pair
    typedef struct packed {
        logic      hit;
        word_sel_e sel;
        logic [7:0] bit_idx;
    } route_t;

    // Slot 0 takes the direct word one bit per port; slots 1.. take
    // consecutive lanes of lane_ports bits in the shared word.
    function automatic route_t route_req(
        input int unsigned slot,
        input int unsigned port,
        input int unsigned n_slots,
        input int unsigned word_w,
        input int unsigned lane_ports
    );
        route_t r;
        r.hit     = 1'b0;
        r.sel     = WSEL_DIRECT;
        r.bit_idx = '0;
        if (slot == 0) begin
            if (port < word_w) begin
                r.hit     = 1'b1;
                r.bit_idx = 8'(port);
            end
        end else if (slot < n_slots && port < lane_ports &&
                     ((slot - 1) * lane_ports + port) < word_w) begin
            r.hit     = 1'b1;
            r.sel     = WSEL_SHARED;
            r.bit_idx = 8'((slot - 1) * lane_ports + port);
        end
        return r;
    endfunction

endpackage

// File: rtl/nirq_req_decode.sv
module nirq_req_decode
    import nirq_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int N_SLOTS    = 5,
    parameter int LANE_PORTS = 4,
    parameter int SLOT_W     = 3,
    parameter int PORT_W     = 4
) (
    input  logic              vld,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PORT_W-1:0] port,
    output logic [WORD_W-1:0] mask_dir,
    output logic [WORD_W-1:0] mask_shr
);

    route_t rt;

    always_comb begin
        rt = route_req(32'(slot), 32'(port), N_SLOTS, WORD_W, LANE_PORTS);
        mask_dir = '0;
        mask_shr = '0;
        if (vld && rt.hit) begin
            unique case (rt.sel)
                WSEL_DIRECT: mask_dir = WORD_W'(1) << rt.bit_idx;
                WSEL_SHARED: mask_shr = WORD_W'(1) << rt.bit_idx;
            endcase
        end
    end

endmodule

// File: rtl/nirq_status_bank.sv
module nirq_status_bank #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_WORDS-1:0][WORD_W-1:0] rise_m,
    input  logic [N_WORDS-1:0][WORD_W-1:0] fall_m,
    output logic [N_WORDS-1:0][WORD_W-1:0] stat_q
);

    // Drop sets a bit to idle (1), raise forces it pending (0) and wins.
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[w] <= '1;
            end else begin
                stat_q[w] <= (stat_q[w] | fall_m[w]) & ~rise_m[w];
            end
        end
    end

endmodule

// File: rtl/nirq_line_fsm.sv
module nirq_line_fsm #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_WORDS-1:0][WORD_W-1:0] stat,
    output logic                           irq
);

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    line_state_e state_q, state_d;
    logic        any_low;

    always_comb begin
        any_low = 1'b0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (stat[w] != '1) any_low = 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (any_low)  state_d = LINE_RAISED;
            LINE_RAISED: if (!any_low) state_d = LINE_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    // output
    always_comb begin
        unique case (state_q)
            LINE_QUIET:  irq = 1'b0;
            LINE_RAISED: irq = 1'b1;
        endcase
    end

endmodule

// File: rtl/nirq_readback.sv
module nirq_readback #(
    parameter int              WORD_W = 16,
    parameter int              ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_DIR = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_SHR = 8'h22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] word_dir,
    input  logic [WORD_W-1:0] word_shr,
    output logic [WORD_W-1:0] data
);

    always_comb begin
        if (addr == ADDR_DIR)      data = word_dir;
        else if (addr == ADDR_SHR) data = word_shr;
        else                       data = '0;
    end

endmodule

// File: rtl/nirq_aggregator.sv
module nirq_aggregator #(
    parameter int              WORD_W      = 16,
    parameter int              N_SLOTS     = 5,
    parameter int              LANE_PORTS  = 4,
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_DIR  = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_SHR  = 8'h22,
    localparam int             SLOT_W      = $clog2(N_SLOTS),
    localparam int             PORT_W      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_vld,
    input  logic [SLOT_W-1:0] raise_slot,
    input  logic [PORT_W-1:0] raise_port,
    input  logic              drop_vld,
    input  logic [SLOT_W-1:0] drop_slot,
    input  logic [PORT_W-1:0] drop_port,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              net_irq
);

    localparam int N_WORDS = 2;

    logic [WORD_W-1:0] rise_dir, rise_shr, fall_dir, fall_shr;
    logic [WORD_W-1:0] stat_dir, stat_shr;
    logic [N_WORDS-1:0][WORD_W-1:0] rise_m, fall_m, stat_q;

    nirq_req_decode #(
        .WORD_W(WORD_W), .N_SLOTS(N_SLOTS), .LANE_PORTS(LANE_PORTS),
        .SLOT_W(SLOT_W), .PORT_W(PORT_W)
    ) u_dec_raise (
        .vld(raise_vld), .slot(raise_slot), .port(raise_port),
        .mask_dir(rise_dir), .mask_shr(rise_shr)
    );

    nirq_req_decode #(
        .WORD_W(WORD_W), .N_SLOTS(N_SLOTS), .LANE_PORTS(LANE_PORTS),
        .SLOT_W(SLOT_W), .PORT_W(PORT_W)
    ) u_dec_drop (
        .vld(drop_vld), .slot(drop_slot), .port(drop_port),
        .mask_dir(fall_dir), .mask_shr(fall_shr)
    );

    assign rise_m[0] = rise_dir;
    assign rise_m[1] = rise_shr;
    assign fall_m[0] = fall_dir;
    assign fall_m[1] = fall_shr;

    nirq_status_bank #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .rise_m(rise_m), .fall_m(fall_m), .stat_q(stat_q)
    );

    assign stat_dir = stat_q[0];
    assign stat_shr = stat_q[1];

    nirq_line_fsm #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_line (
        .clk(clk), .rst_n(rst_n), .stat(stat_q), .irq(net_irq)
    );

    nirq_readback #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W),
        .ADDR_DIR(ADDR_DIR), .ADDR_SHR(ADDR_SHR)
    ) u_rd (
        .addr(rd_addr), .word_dir(stat_dir), .word_shr(stat_shr),
        .data(rd_data)
    );

endmodule

// File: rtl/nirq_aggregator_chk.sv
module nirq_aggregator_chk #(
    parameter int WORD_W     = 16,
    parameter int N_SLOTS    = 5,
    parameter int LANE_PORTS = 4,
    parameter int SLOT_W     = 3,
    parameter int PORT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raise_vld,
    input logic [SLOT_W-1:0] raise_slot,
    input logic [PORT_W-1:0] raise_port,
    input logic [WORD_W-1:0] rise_dir,
    input logic [WORD_W-1:0] rise_shr,
    input logic [WORD_W-1:0] fall_dir,
    input logic [WORD_W-1:0] fall_shr,
    input logic [WORD_W-1:0] stat_dir,
    input logic [WORD_W-1:0] stat_shr,
    input logic              net_irq
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R5: line reflects the status words one edge later
    a_r5_line_lags: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (net_irq == $past((stat_dir != '1) || (stat_shr != '1))));

    // R9 / R2: a raised bit is pending after the edge, even if dropped too
    a_r9_raise_wins_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_dir) |=> ((stat_dir & $past(rise_dir)) == '0));
    a_r9_raise_wins_shr: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_shr) |=> ((stat_shr & $past(rise_shr)) == '0));

    // R4: a dropped bit not raised at once returns to idle
    a_r4_drop_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fall_dir & ~rise_dir)) |=>
        ((stat_dir & $past(fall_dir & ~rise_dir)) == $past(fall_dir & ~rise_dir)));
    a_r4_drop_shr: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fall_shr & ~rise_shr)) |=>
        ((stat_shr & $past(fall_shr & ~rise_shr)) == $past(fall_shr & ~rise_shr)));

    // R8: bits outside both strobes hold their value
    a_r8_rest_stable: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((((stat_dir ^ $past(stat_dir)) & ~$past(rise_dir | fall_dir)) == '0) &&
                     (((stat_shr ^ $past(stat_shr)) & ~$past(rise_shr | fall_shr)) == '0)));

    // R7: at most one bit per strobe, none for out-of-range numbers
    a_r7_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_shr, rise_dir}));
    a_r7_bad_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && (32'(raise_slot) >= N_SLOTS)) |-> (rise_dir == '0 && rise_shr == '0));
    a_r3_bad_lane_port: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && raise_slot != '0 && (32'(raise_port) >= LANE_PORTS)) |->
        (rise_dir == '0 && rise_shr == '0));

endmodule

bind nirq_aggregator nirq_aggregator_chk #(
    .WORD_W(WORD_W), .N_SLOTS(N_SLOTS), .LANE_PORTS(LANE_PORTS),
    .SLOT_W(SLOT_W), .PORT_W(PORT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .raise_vld(raise_vld), .raise_slot(raise_slot), .raise_port(raise_port),
    .rise_dir(rise_dir), .rise_shr(rise_shr),
    .fall_dir(fall_dir), .fall_shr(fall_shr),
    .stat_dir(stat_dir), .stat_shr(stat_shr),
    .net_irq(net_irq)
);

// File: tb/nirq_aggregator_tb.sv
`timescale 1ns/1ps
module nirq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_vld = 1'b0, drop_vld = 1'b0;
    logic [2:0]  raise_slot = '0, drop_slot = '0;
    logic [3:0]  raise_port = '0, drop_port = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        net_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_dir = 16'hFFFF;
    logic [15:0] exp_shr = 16'hFFFF;

    always #4 clk = ~clk;   // 125 MHz

    nirq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n),
        .raise_vld(raise_vld), .raise_slot(raise_slot), .raise_port(raise_port),
        .drop_vld(drop_vld), .drop_slot(drop_slot), .drop_port(drop_port),
        .rd_addr(rd_addr), .rd_data(rd_data), .net_irq(net_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // Model: mark one bit in the expected words
    task automatic model(input int slot, input int port, input logic val);
        if (slot == 0 && port < 16) exp_dir[port] = val;
        else if (slot >= 1 && slot <= 4 && port < 4) exp_shr[(slot-1)*4 + port] = val;
    endtask

    function automatic logic exp_any();
        return (exp_dir != 16'hFFFF) || (exp_shr != 16'hFFFF);
    endfunction

    task automatic check_words(input string req);
        rd_addr = 8'h20; #1; chk({req, " direct word"}, 32'(rd_data), 32'(exp_dir));
        rd_addr = 8'h22; #1; chk({req, " shared word"}, 32'(rd_data), 32'(exp_shr));
    endtask

    // One strobe cycle; leaves the bench just after the status edge.
    // Returns the line value expected before the update reaches it.
    task automatic strobe(input logic rv, input int rs, input int rp,
                          input logic dv, input int ds, input int dp,
                          output logic old_irq);
        @(negedge clk);
        old_irq    = exp_any();
        raise_vld  = rv; raise_slot = 3'(rs); raise_port = 4'(rp);
        drop_vld   = dv; drop_slot  = 3'(ds); drop_port  = 4'(dp);
        if (dv) model(ds, dp, 1'b1);
        if (rv) model(rs, rp, 1'b0);
        @(negedge clk);
        raise_vld = 1'b0; drop_vld = 1'b0;
    endtask

    task automatic settle_irq(input string req);
        @(negedge clk);
        chk(req, 32'(net_irq), 32'(exp_any()));
    endtask

    task automatic t_reset();
        check_words("R1 reset");
        chk("R1 reset irq", 32'(net_irq), 32'h0);
        rd_addr = 8'h24; #1; chk("R6 unmapped addr", 32'(rd_data), 32'h0);
        rd_addr = 8'h21; #1; chk("R6 unmapped addr", 32'(rd_data), 32'h0);
    endtask

    task automatic t_slot0();
        logic o;
        strobe(1, 0, 0, 0, 0, 0, o);
        check_words("R2 slot0 port0");
        chk("R5 irq lags one cycle", 32'(net_irq), 32'(o));
        settle_irq("R5 irq rises");
        for (int p = 1; p < 16; p++) begin
            strobe(1, 0, p, 0, 0, 0, o);
            check_words("R2 slot0 port");
        end
        for (int p = 0; p < 16; p++) begin
            strobe(0, 0, 0, 1, 0, p, o);
            check_words("R4 slot0 drop");
        end
        chk("R5 irq held while clearing last", 32'(net_irq), 32'h1);
        settle_irq("R5 irq falls");
    endtask

    task automatic t_shared();
        logic o;
        for (int s = 1; s <= 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                strobe(1, s, p, 0, 0, 0, o);
                check_words("R3 shared raise");
                settle_irq("R5 irq shared");
                strobe(0, 0, 0, 1, s, p, o);
                check_words("R4 shared drop");
                settle_irq("R5 irq shared clear");
            end
        end
    endtask

    task automatic t_out_of_range();
        logic o;
        strobe(1, 5, 0, 0, 0, 0, o); check_words("R7 slot 5");
        strobe(1, 7, 2, 0, 0, 0, o); check_words("R7 slot 7");
        strobe(1, 2, 4, 0, 0, 0, o); check_words("R7 slot2 port4");
        strobe(1, 4, 15, 0, 0, 0, o); check_words("R7 slot4 port15");
        settle_irq("R7 irq stays low");
    endtask

    task automatic t_simul();
        logic o;
        strobe(1, 0, 3, 0, 0, 0, o);
        strobe(1, 1, 0, 1, 0, 3, o);
        check_words("R8 raise and drop differ");
        strobe(1, 3, 2, 1, 3, 2, o);
        check_words("R9 same bit raise wins");
        strobe(0, 0, 0, 1, 1, 0, o);
        strobe(0, 0, 0, 1, 3, 2, o);
        check_words("R4 cleanup");
        settle_irq("R5 irq after cleanup");
    endtask

    task automatic t_read_noeffect();
        logic o;
        strobe(1, 4, 3, 0, 0, 0, o);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rd_addr = (i % 2 == 0) ? 8'h20 : 8'h22;
        end
        check_words("R6 reads leave bits");
        chk("R6 top shared bit", 32'(exp_shr), 32'h7FFF);
        settle_irq("R5 irq after reads");
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slot0();
        t_shared();
        t_out_of_range();
        t_simul();
        t_read_noeffect();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule